// File: doc/BRIEF.md
# PHY Control-Register Transaction Engine

This block is a hardware engine for a PHY's narrow control-register side bus. Without it, software would toggle those strobes one register write at a time. The host side is a small command port. Software or a boot sequencer presents one command: a read or write opcode, a 16-bit register address and, for writes, 16-bit data. The engine then runs every handshake on the side bus and returns the read data, a one-cycle done pulse and a timeout flag.

The side bus has one shared 16-bit bus toward the PHY, which carries the address and the write data. It also has four strobes: latch-address, latch-data, read and write. Two signals come back from the PHY: a 16-bit result bus and a single acknowledge line.

Every access starts with an address phase. A read adds a read phase. A write adds a data-latch phase and then a separate write phase. In each phase the engine first holds its strobe low for one cycle with the bus value already in place. It then raises the strobe, waits for the acknowledge to go high, drops the strobe and waits for the acknowledge to go low.

Each wait is bounded by a cycle budget. When the budget runs out, the engine moves on anyway and records the timeout. The acknowledge line is resynchronised before use, because the PHY may run on another clock.

Top module: `phyctl_xact_engine`

## Requirements
- R1: After reset, cmd_ready is 1, all four strobes are 0, rsp_done is 0, rsp_timeout is 0 and rsp_rdata is 0.
- R2: A read (cmd_write = 0) runs an address phase and then a read-strobe phase. rsp_rdata takes the value of phy_dout at the moment the synchronised acknowledge is first seen high in the read phase, or when that wait times out.
- R3: A write (cmd_write = 1) runs an address phase, then a data-latch phase, then a write-strobe phase. A later read of the same address returns the written data.
- R4: At most one strobe is high in any cycle. Each strobe falls before any other strobe rises, with at least one cycle in which all strobes are low.
- R5: While the address-latch strobe is high, phy_din carries the command address. While the data-latch strobe is high, phy_din carries the command write data.
- R6: Each wait for the acknowledge to rise lasts at most TIMEOUT_CYC cycles, after which the sequence continues. With an acknowledge that never rises, done comes 2*TIMEOUT_CYC+4 cycles after acceptance for a read and 3*TIMEOUT_CYC+6 cycles after for a write.
- R7: Each wait for the acknowledge to fall is bounded the same way. With an acknowledge stuck high, a read completes 2*TIMEOUT_CYC+4 cycles after acceptance.
- R8: rsp_timeout is set when any wait of a command expires. It stays set after done and is cleared when the next command is accepted.
- R9: A command is accepted only at a rising edge where cmd_valid and cmd_ready are both 1. cmd_valid while busy has no effect on the bus or on the target registers.
- R10: rsp_done is high for exactly one cycle per command, and cmd_ready is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_ready | output | 1 | Engine idle, command can be accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data returned by the last read |
| rsp_timeout | output | 1 | Sticky flag: a wait of the last command expired |
| phy_din | output | 16 | Shared address/data bus toward the PHY |
| phy_cap_addr | output | 1 | Address-latch strobe |
| phy_cap_data | output | 1 | Data-latch strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write strobe |
| phy_dout | input | 16 | Read result from the PHY |
| phy_ack | input | 1 | Acknowledge from the PHY (asynchronous) |

## Verification
With a silent or stuck-high acknowledge the timing is fully determined. Each phase then costs TIMEOUT_CYC+2 cycles, so done is due exactly 2*TIMEOUT_CYC+4 cycles after acceptance for a read and 3*TIMEOUT_CYC+6 for a write. The scoreboard records the accepting edge and compares the measured distance to the done pulse against that figure.

With a responsive model PHY, the exact latency depends on the model's delay. In that case only the returned data and flag are compared, sampled at the falling edge inside the done cycle.

The sticky flag is sampled three cycles after done to confirm it still holds. It is checked again at the following done to confirm it was cleared.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WAIT_HI,
      ST_WAIT_LO
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_DATA,
      PH_ACT
   } seq_phase_t;
endpackage

// File: rtl/phyctl_ack_sync.sv
module phyctl_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/phyctl_wait_timer.sv
module phyctl_wait_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  cnt_q <= '0;
      else if (!expired)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LAST);

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/phyctl_sequencer.sv
module phyctl_sequencer
   import phyctl_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [BUS_W-1:0] cmd_addr,
   input  logic [BUS_W-1:0] cmd_wdata,
   output logic             cmd_ready,
   output logic             rsp_done,
   output logic [BUS_W-1:0] rsp_rdata,
   output logic             rsp_timeout,
   output logic [BUS_W-1:0] phy_din,
   output logic             phy_cap_addr,
   output logic             phy_cap_data,
   output logic             phy_rd,
   output logic             phy_wr,
   input  logic [BUS_W-1:0] phy_dout,
   input  logic             ack_s,
   input  logic             tmr_expired,
   output logic             tmr_clr
);
   seq_state_t       st_q, st_d;
   seq_phase_t       ph_q, ph_d;
   logic             wr_q;
   logic [BUS_W-1:0] addr_q, wdata_q, din_q, rdata_q;
   logic             to_q, done_q;
   logic             accept, leave_hi, leave_lo, fin, in_wait;

   assign accept   = (st_q == ST_IDLE) && cmd_valid;
   assign leave_hi = (st_q == ST_WAIT_HI) && (ack_s || tmr_expired);
   assign leave_lo = (st_q == ST_WAIT_LO) && (!ack_s || tmr_expired);
   assign fin      = leave_lo && (ph_q == PH_ACT);
   assign in_wait  = (st_q == ST_WAIT_HI) || (st_q == ST_WAIT_LO);
   assign tmr_clr  = !in_wait || leave_hi || leave_lo;

   always_comb begin
      st_d = st_q;
      ph_d = ph_q;
      case (st_q)
         ST_IDLE:    if (cmd_valid) begin st_d = ST_SETUP; ph_d = PH_ADDR; end
         ST_SETUP:   st_d = ST_WAIT_HI;
         ST_WAIT_HI: if (leave_hi) st_d = ST_WAIT_LO;
         ST_WAIT_LO: if (leave_lo) begin
            case (ph_q)
               PH_ADDR: begin st_d = ST_SETUP; ph_d = wr_q ? PH_DATA : PH_ACT; end
               PH_DATA: begin st_d = ST_SETUP; ph_d = PH_ACT; end
               default: st_d = ST_IDLE;
            endcase
         end
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ph_q    <= PH_ADDR;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         din_q   <= '0;
         rdata_q <= '0;
         to_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         done_q <= fin;
         if (accept) begin
            wr_q    <= cmd_write;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            din_q   <= cmd_addr;
            to_q    <= 1'b0;
         end else begin
            if (leave_lo && ph_q == PH_ADDR && wr_q) din_q <= wdata_q;
            if ((st_q == ST_WAIT_HI && tmr_expired && !ack_s) ||
                (st_q == ST_WAIT_LO && tmr_expired && ack_s))
               to_q <= 1'b1;
            if (leave_hi && ph_q == PH_ACT && !wr_q) rdata_q <= phy_dout;
         end
      end
   end

   assign cmd_ready    = (st_q == ST_IDLE);
   assign rsp_done     = done_q;
   assign rsp_rdata    = rdata_q;
   assign rsp_timeout  = to_q;
   assign phy_din      = din_q;
   assign phy_cap_addr = (st_q == ST_WAIT_HI) && (ph_q == PH_ADDR);
   assign phy_cap_data = (st_q == ST_WAIT_HI) && (ph_q == PH_DATA);
   assign phy_rd       = (st_q == ST_WAIT_HI) && (ph_q == PH_ACT) && !wr_q;
   assign phy_wr       = (st_q == ST_WAIT_HI) && (ph_q == PH_ACT) && wr_q;

   // R4
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phy_cap_addr, phy_cap_data, phy_rd, phy_wr}));
   // R4
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_cap_addr | phy_cap_data | phy_rd | phy_wr)
      |-> $past({phy_cap_addr, phy_cap_data, phy_rd, phy_wr}) == 4'b0);
   // R5
   din_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_cap_addr |-> phy_din == addr_q);
   // R5
   din_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_cap_data |-> phy_din == wdata_q);
   // R8
   to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !rsp_timeout);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> $stable(addr_q) && $stable(wr_q));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   // R10
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> cmd_ready);
endmodule

// File: rtl/phyctl_xact_engine.sv
module phyctl_xact_engine #(
   parameter int BUS_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [BUS_W-1:0] cmd_addr,
   input  logic [BUS_W-1:0] cmd_wdata,
   output logic             cmd_ready,
   output logic             rsp_done,
   output logic [BUS_W-1:0] rsp_rdata,
   output logic             rsp_timeout,
   output logic [BUS_W-1:0] phy_din,
   output logic             phy_cap_addr,
   output logic             phy_cap_data,
   output logic             phy_rd,
   output logic             phy_wr,
   input  logic [BUS_W-1:0] phy_dout,
   input  logic             phy_ack
);
   generate
      if (BUS_W < 1) begin : g_bad_width
         $error("BUS_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic ack_s, tmr_expired, tmr_clr;

   phyctl_ack_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (phy_ack),
      .sync_out (ack_s)
   );

   phyctl_wait_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .expired (tmr_expired)
   );

   phyctl_sequencer #(.BUS_W(BUS_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_write    (cmd_write),
      .cmd_addr     (cmd_addr),
      .cmd_wdata    (cmd_wdata),
      .cmd_ready    (cmd_ready),
      .rsp_done     (rsp_done),
      .rsp_rdata    (rsp_rdata),
      .rsp_timeout  (rsp_timeout),
      .phy_din      (phy_din),
      .phy_cap_addr (phy_cap_addr),
      .phy_cap_data (phy_cap_data),
      .phy_rd       (phy_rd),
      .phy_wr       (phy_wr),
      .phy_dout     (phy_dout),
      .ack_s        (ack_s),
      .tmr_expired  (tmr_expired),
      .tmr_clr      (tmr_clr)
   );
endmodule

// File: tb/test_phyctl_xact_engine.sv
`timescale 1ns/1ps
module test_phyctl_xact_engine;
   localparam int T = 12;
   localparam logic [15:0] FIXED_DOUT = 16'hC0DE;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid, cmd_write;
   logic [15:0] cmd_addr, cmd_wdata;
   logic        cmd_ready, rsp_done, rsp_timeout;
   logic [15:0] rsp_rdata, phy_din, phy_dout;
   logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr, phy_ack;

   always #2 clk = ~clk;

   phyctl_xact_engine #(.BUS_W(16), .SYNC_STAGES(2), .TIMEOUT_CYC(T)) i_phyctl_xact_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
      .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
      .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_dout(phy_dout), .phy_ack(phy_ack));

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- model PHY: 0 normal, 1 silent, 2 ack stuck high
   int          mode = 0;
   logic [15:0] mem [16];
   logic [15:0] m_addr, m_data, m_dout;
   logic [1:0]  ack_pipe;
   logic [3:0]  prev_stb;
   logic [15:0] cur_addr, cur_wdata;
   wire  [3:0]  stb = {phy_cap_addr, phy_cap_data, phy_rd, phy_wr};

   assign phy_ack  = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : ack_pipe[1];
   assign phy_dout = (mode == 0) ? m_dout : FIXED_DOUT;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 16'h1000 + 16'(i);
         m_addr <= '0; m_data <= '0; m_dout <= '0; ack_pipe <= '0; prev_stb <= '0;
      end else begin
         prev_stb <= stb;
         ack_pipe <= {ack_pipe[0], |stb};
         if (mode == 0) begin
            if (stb[3] && !prev_stb[3]) begin
               m_addr <= phy_din;
               chk(phy_din == cur_addr, "R5", "address on bus", phy_din, cur_addr);
            end
            if (stb[2] && !prev_stb[2]) begin
               m_data <= phy_din;
               chk(phy_din == cur_wdata, "R5", "data on bus", phy_din, cur_wdata);
            end
            if (stb[1] && !prev_stb[1]) m_dout <= mem[m_addr[3:0]];
            if (stb[0] && !prev_stb[0]) mem[m_addr[3:0]] <= m_data;
         end
      end
   end

   // ---------------- protocol monitors (R4, R10)
   int   r4_bad = 0, r10_bad = 0;
   logic done_prev = 1'b0;
   logic [3:0] stb_prev = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if ($countones(stb) > 1) r4_bad++;
         if (stb != 4'b0 && stb_prev != 4'b0 && stb != stb_prev) r4_bad++;
         if (done_prev && rsp_done) r10_bad++;
         if (rsp_done && !cmd_ready) r10_bad++;
      end
      stb_prev  = stb;
      done_prev = rsp_done;
   end

   // ---------------- scoreboard
   typedef struct {
      bit          is_rd;
      logic [15:0] rdata;
      bit          to;
      int          lat;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   int cyc = 0, start_cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && cmd_valid && cmd_ready) start_cyc <= cyc;
   end

   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected completion", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.is_rd) chk(rsp_rdata == e.rdata, e.req, "read data", rsp_rdata, e.rdata);
            chk(rsp_timeout == e.to, e.to ? e.req : "R8", "timeout flag", rsp_timeout, e.to);
            if (e.lat >= 0)
               chk(cyc - start_cyc - 1 == e.lat, e.req, "latency", cyc - start_cyc - 1, e.lat);
         end
      end
   end

   task automatic send(input bit wr, input logic [15:0] addr, input logic [15:0] wdata,
                       input logic [15:0] xrd, input bit xto, input int xlat,
                       input string req, input bit intrude);
      exp_t e;
      e.is_rd = !wr; e.rdata = xrd; e.to = xto; e.lat = xlat; e.req = req;
      while (!cmd_ready) @(negedge clk);
      exp_q.push_back(e);
      cur_addr  = addr;
      cur_wdata = wdata;
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_wdata = wdata;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (intrude) begin
         @(negedge clk);
         cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = addr; cmd_wdata = 16'hBAD0;
         repeat (5) @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!rsp_done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      chk(r4_bad == 0, "R4", "strobe overlap or no gap", r4_bad, 0);
      chk(r10_bad == 0, "R10", "done pulse shape", r10_bad, 0);
      chk(exp_q.size() == 0, "R10", "missing completions", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R6", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
      cur_addr = '0; cur_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1'b1, "R1", "ready", cmd_ready, 1);
      chk(stb == 4'b0, "R1", "strobes", stb, 0);
      chk(rsp_done == 1'b0 && rsp_timeout == 1'b0, "R1", "done/timeout",
          {rsp_done, rsp_timeout}, 0);
      chk(rsp_rdata == 16'h0, "R1", "rdata", rsp_rdata, 0);

      // R3 / R2 responsive PHY
      send(1'b1, 16'h0005, 16'hA5A5, 16'h0, 1'b0, -1, "R3", 1'b0);
      send(1'b0, 16'h0005, 16'h0,    16'hA5A5, 1'b0, -1, "R2", 1'b0);
      send(1'b1, 16'h0009, 16'h1234, 16'h0, 1'b0, -1, "R3", 1'b0);
      send(1'b0, 16'h0009, 16'h0,    16'h1234, 1'b0, -1, "R3", 1'b0);
      send(1'b0, 16'h0002, 16'h0,    16'h1002, 1'b0, -1, "R2", 1'b0);

      // R9 cmd_valid while busy is ignored
      send(1'b1, 16'h0003, 16'h3333, 16'h0, 1'b0, -1, "R9", 1'b1);
      send(1'b0, 16'h0003, 16'h0,    16'h3333, 1'b0, -1, "R9", 1'b0);

      // R6 silent PHY: read then write, fixed latency
      mode = 1;
      repeat (4) @(negedge clk);
      send(1'b0, 16'h0007, 16'h0, FIXED_DOUT, 1'b1, 2*T+4, "R6", 1'b0);
      repeat (3) @(negedge clk);
      chk(rsp_timeout == 1'b1, "R8", "flag sticky after done", rsp_timeout, 1);
      send(1'b1, 16'h0007, 16'hFFFF, 16'h0, 1'b1, 3*T+6, "R6", 1'b0);

      // R7 acknowledge stuck high
      mode = 2;
      repeat (4) @(negedge clk);
      send(1'b0, 16'h0004, 16'h0, FIXED_DOUT, 1'b1, 2*T+4, "R7", 1'b0);

      // R8 next command clears the flag; silent write left target untouched
      mode = 0;
      repeat (6) @(negedge clk);
      send(1'b0, 16'h0007, 16'h0, 16'h1007, 1'b0, -1, "R8", 1'b0);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule